// File: doc/BRIEF.md
# Two-Bit Digit-Serial ALU

This unit does integer arithmetic and logic on 8-bit or 16-bit operands two bits at a time, starting with the least significant digit. A caller pulses `start` together with the first operand digits, an operation code, a width select, a direction bit and the incoming carry flag. On each following cycle it supplies the next pair of operand digits. The unit returns a 2-bit result digit in the same cycle as the operand digits it came from. A carry/borrow bit is held between digits, so a 16-bit add costs eight cycles and a single 2-bit adder slice.

The `swap` bit exchanges the operands before any computation. Without it the operation is `reg op src`, where `reg` is `a_dig` and `src` is `b_dig`; with it the operation is `src op reg`. Beyond the usual add, subtract and bitwise set, the unit offers:
- reversed subtraction;
- negation, with or without the carry flag;
- logic forms that invert the second operand.

Compare and test update only the flags. Flags are registered once the last digit is done and hold until the next operation ends.

Top module: `digit_alu`

## Requirements
- R1: After an accepted `start`, `res_valid` is high for exactly 4 consecutive cycles when `wide`=0 (8 bits) or 8 cycles when `wide`=1 (16 bits). Digit k of the result (bits 2k+1:2k) appears on `res_dig` in the same cycle that operand digit k is on `a_dig`/`b_dig`, with digit 0 in the `start` cycle.
- R2: `done` is high only in the cycle that carries the final result digit.
- R3: The arithmetic codes and their results are:

  | Code | Operation | Result |
  |---|---|---|
  | 0 | add | x+y |
  | 1 | add with carry | x+y+cin |
  | 2 | subtract | x+~y+1 |
  | 3 | subtract with borrow | x+~y+cin |

  Here x and y are the operands after the `swap` step. The C flag is the carry out of the top bit, so for a subtract C=1 means no borrow.
- R4: The logic codes and their results are:

  | Code | Result |
  |---|---|
  | 4 | x&y |
  | 5 | x\|y |
  | 6 | x^y |
  | 13 | x&~y |
  | 14 | x\|~y |
  | 15 | x^~y |
  | 16 | ~y |

  Every logic operation clears C and V.
- R5: Code 7 (compare) sets the flags as code 2 does, and code 8 (test) sets them as code 4 does. For both, `wb` stays low; for every other defined code, `wb` equals `res_valid`.
- R6: The negate and reversed-subtract codes and their results are:

  | Code | Operation | Result |
  |---|---|---|
  | 9 | negate | 0+~y+1 |
  | 10 | negate with carry | 0+~y+cin |
  | 11 | reversed subtract | y+~x+1 |
  | 12 | reversed subtract with borrow | y+~x+cin |

  C and V are computed as for an addition of the two shown terms.
- R7: `swap`=0 gives x=`a_dig` and y=`b_dig`; `swap`=1 gives x=`b_dig` and y=`a_dig`.
- R8: The flags are set as follows, become visible in the cycle after `done`, and hold until the next `done`:
  - Z is 1 when the whole result is zero;
  - S is the top result bit;
  - V is the signed overflow of the addition.
- R9: `op`, `wide`, `swap` and `c_in` are sampled only in the cycle `start` is accepted. A `start` while an operation is in progress is ignored.
- R10: A `start` with an undefined code (17 to 31) is ignored: `res_valid`, `wb` and `done` stay low and the flags are unchanged.
- R11: After reset, `res_valid`, `wb` and `done` are low and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | First digit of a new operation is present |
| op | input | 5 | Operation code |
| wide | input | 1 | 0: 8-bit operands, 1: 16-bit operands |
| swap | input | 1 | Exchange operands before computing |
| c_in | input | 1 | Incoming carry flag for the with-carry forms |
| a_dig | input | 2 | Current digit of the reg operand |
| b_dig | input | 2 | Current digit of the src operand |
| res_dig | output | 2 | Current result digit |
| res_valid | output | 1 | A result digit is being produced |
| wb | output | 1 | Result digit should be written back |
| done | output | 1 | Final digit of the operation |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |

## Verification
A wrong carry-chain bit shows up on `res_dig` in the very next digit cycle and again in C and V one cycle after `done`. A wrong zero accumulator stays hidden until Z is compared after the operation. A digit counter that is off shows at once as `done` in the wrong cycle, or as `res_valid` lasting too long or too short. The bench checks every digit on every cycle against an integer model of the whole operation, then checks all four flags the cycle after. This pins down where each fault appears.

// File: rtl/digit_alu_pkg.sv
package digit_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_CMP  = 5'd7,
        OP_TEST = 5'd8,
        OP_NEG  = 5'd9,
        OP_NEGC = 5'd10,
        OP_RSUB = 5'd11,
        OP_RSBC = 5'd12,
        OP_ANDN = 5'd13,
        OP_ORN  = 5'd14,
        OP_XORN = 5'd15,
        OP_NOT  = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_sel_e;

    typedef enum logic [1:0] {
        LF_AND  = 2'd0,
        LF_OR   = 2'd1,
        LF_XOR  = 2'd2,
        LF_PASS = 2'd3
    } logic_fn_e;

    typedef struct packed {
        logic      valid;
        logic      arith;
        logic      zero_x;
        logic      inv_x;
        logic      inv_y;
        cin_sel_e  cin;
        logic_fn_e lfn;
        logic      wb;
    } alu_ctl_t;

endpackage

// File: rtl/digit_alu_opdec.sv
module digit_alu_opdec
    import digit_alu_pkg::*;
(
    input  logic [4:0] op_i,
    output alu_ctl_t   ctl_o
);

    always_comb begin
        ctl_o        = '0;
        ctl_o.valid  = 1'b1;
        ctl_o.wb     = 1'b1;
        ctl_o.cin    = CIN_ZERO;
        ctl_o.lfn    = LF_AND;
        case (op_i)
            OP_ADD:  begin ctl_o.arith = 1'b1; end
            OP_ADC:  begin ctl_o.arith = 1'b1; ctl_o.cin = CIN_FLAG; end
            OP_SUB:  begin ctl_o.arith = 1'b1; ctl_o.inv_y = 1'b1; ctl_o.cin = CIN_ONE; end
            OP_SBC:  begin ctl_o.arith = 1'b1; ctl_o.inv_y = 1'b1; ctl_o.cin = CIN_FLAG; end
            OP_CMP:  begin ctl_o.arith = 1'b1; ctl_o.inv_y = 1'b1; ctl_o.cin = CIN_ONE;
                           ctl_o.wb = 1'b0; end
            OP_NEG:  begin ctl_o.arith = 1'b1; ctl_o.zero_x = 1'b1; ctl_o.inv_y = 1'b1;
                           ctl_o.cin = CIN_ONE; end
            OP_NEGC: begin ctl_o.arith = 1'b1; ctl_o.zero_x = 1'b1; ctl_o.inv_y = 1'b1;
                           ctl_o.cin = CIN_FLAG; end
            OP_RSUB: begin ctl_o.arith = 1'b1; ctl_o.inv_x = 1'b1; ctl_o.cin = CIN_ONE; end
            OP_RSBC: begin ctl_o.arith = 1'b1; ctl_o.inv_x = 1'b1; ctl_o.cin = CIN_FLAG; end
            OP_AND:  begin ctl_o.lfn = LF_AND; end
            OP_TEST: begin ctl_o.lfn = LF_AND; ctl_o.wb = 1'b0; end
            OP_OR:   begin ctl_o.lfn = LF_OR; end
            OP_XOR:  begin ctl_o.lfn = LF_XOR; end
            OP_ANDN: begin ctl_o.lfn = LF_AND; ctl_o.inv_y = 1'b1; end
            OP_ORN:  begin ctl_o.lfn = LF_OR; ctl_o.inv_y = 1'b1; end
            OP_XORN: begin ctl_o.lfn = LF_XOR; ctl_o.inv_y = 1'b1; end
            OP_NOT:  begin ctl_o.lfn = LF_PASS; ctl_o.inv_y = 1'b1; end
            default: begin ctl_o.valid = 1'b0; ctl_o.wb = 1'b0; end
        endcase
    end

    // R10: an undefined code never requests writeback
    always_comb begin
        a_r10_undef_no_wb: assert (ctl_o.valid || !ctl_o.wb);
    end

endmodule

// File: rtl/digit_alu_slice.sv
module digit_alu_slice
    import digit_alu_pkg::*;
#(
    parameter int DW = 2
) (
    input  logic [DW-1:0] p_i,
    input  logic [DW-1:0] q_i,
    input  logic          c_i,
    input  logic          arith_i,
    input  logic_fn_e     fn_i,
    output logic [DW-1:0] r_o,
    output logic          c_o,
    output logic          c_top_o
);

    logic [DW:0]   chain;
    logic [DW-1:0] sum_bits;
    logic [DW-1:0] log_bits;

    assign chain[0] = c_i;

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign sum_bits[g]  = p_i[g] ^ q_i[g] ^ chain[g];
        assign chain[g + 1] = (p_i[g] & q_i[g]) | (chain[g] & (p_i[g] ^ q_i[g]));
        assign log_bits[g]  = (fn_i == LF_AND) ? (p_i[g] & q_i[g]) :
                              (fn_i == LF_OR)  ? (p_i[g] | q_i[g]) :
                              (fn_i == LF_XOR) ? (p_i[g] ^ q_i[g]) : q_i[g];
    end

    assign r_o     = arith_i ? sum_bits : log_bits;
    assign c_o     = chain[DW];
    assign c_top_o = chain[DW-1];

endmodule

// File: rtl/digit_alu.sv
module digit_alu
    import digit_alu_pkg::*;
#(
    parameter int DW       = 2,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [4:0]    op,
    input  logic          wide,
    input  logic          swap,
    input  logic          c_in,
    input  logic [DW-1:0] a_dig,
    input  logic [DW-1:0] b_dig,
    output logic [DW-1:0] res_dig,
    output logic          res_valid,
    output logic          wb,
    output logic          done,
    output logic          flag_c,
    output logic          flag_z,
    output logic          flag_s,
    output logic          flag_v
);

    localparam int NDIG_N = NARROW_W / DW;
    localparam int NDIG_W = WIDE_W / DW;
    localparam int CW     = (NDIG_W > 1) ? $clog2(NDIG_W) : 1;
    localparam logic [CW-1:0] LAST_N = CW'(NDIG_N - 1);
    localparam logic [CW-1:0] LAST_W = CW'(NDIG_W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          carry;
        logic          zacc;
        alu_ctl_t      ctl;
        logic          wide;
        logic          swap;
        logic          cflag;
        logic          fc;
        logic          fz;
        logic          fs;
        logic          fv;
    } state_t;

    state_t st_d, st_q;

    alu_ctl_t      dec_ctl;
    alu_ctl_t      cur_ctl;
    logic          accept;
    logic          active;
    logic          cur_wide;
    logic          cur_swap;
    logic          cur_cflag;
    logic [CW-1:0] cur_cnt;
    logic          first;
    logic          last;
    logic [DW-1:0] x_dig, y_dig, p_dig, q_dig, r_dig;
    logic          dig_cin, dig_cout, dig_ctop;
    logic          zacc_d;

    digit_alu_opdec u_dec (
        .op_i  (op),
        .ctl_o (dec_ctl)
    );

    digit_alu_slice #(.DW(DW)) u_slice (
        .p_i     (p_dig),
        .q_i     (q_dig),
        .c_i     (dig_cin),
        .arith_i (cur_ctl.arith),
        .fn_i    (cur_ctl.lfn),
        .r_o     (r_dig),
        .c_o     (dig_cout),
        .c_top_o (dig_ctop)
    );

    always_comb begin
        accept    = start && !st_q.busy && dec_ctl.valid;
        cur_ctl   = accept ? dec_ctl : st_q.ctl;
        cur_wide  = accept ? wide    : st_q.wide;
        cur_swap  = accept ? swap    : st_q.swap;
        cur_cflag = accept ? c_in    : st_q.cflag;
        cur_cnt   = accept ? '0      : st_q.cnt;
        active    = (accept || st_q.busy) && cur_ctl.valid;
        first     = (cur_cnt == '0);
        last      = (cur_cnt == (cur_wide ? LAST_W : LAST_N));

        x_dig = cur_swap ? b_dig : a_dig;
        y_dig = cur_swap ? a_dig : b_dig;
        p_dig = cur_ctl.zero_x ? '0 : (cur_ctl.inv_x ? ~x_dig : x_dig);
        q_dig = cur_ctl.inv_y ? ~y_dig : y_dig;

        if (first) begin
            case (cur_ctl.cin)
                CIN_ONE:  dig_cin = 1'b1;
                CIN_FLAG: dig_cin = cur_cflag;
                default:  dig_cin = 1'b0;
            endcase
        end else begin
            dig_cin = st_q.carry;
        end

        zacc_d = (first ? 1'b1 : st_q.zacc) & (r_dig == '0);

        st_d = st_q;
        if (active) begin
            st_d.busy  = !last;
            st_d.cnt   = cur_cnt + CW'(1);
            st_d.carry = dig_cout;
            st_d.zacc  = zacc_d;
            st_d.ctl   = cur_ctl;
            st_d.wide  = cur_wide;
            st_d.swap  = cur_swap;
            st_d.cflag = cur_cflag;
            if (last) begin
                st_d.fc = cur_ctl.arith & dig_cout;
                st_d.fz = zacc_d;
                st_d.fs = r_dig[DW-1];
                st_d.fv = cur_ctl.arith & (dig_cout ^ dig_ctop);
            end
        end

        res_valid = active;
        res_dig   = active ? r_dig : '0;
        wb        = active & cur_ctl.wb;
        done      = active & last;
        flag_c    = st_q.fc;
        flag_z    = st_q.fz;
        flag_s    = st_q.fs;
        flag_v    = st_q.fv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the final digit ends the operation
    a_r2_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.busy);

    // R8: flags move only after a final digit
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable({flag_c, flag_z, flag_s, flag_v}));

    // R9: latched controls stay fixed mid-operation
    a_r9_ctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done) |=> ($stable(st_q.ctl) && $stable(st_q.wide) && $stable(st_q.swap)));

    // R1: digit counter stays within the selected width
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt <= (st_q.wide ? LAST_W : LAST_N)));

    // R5: writeback only accompanies a valid digit
    a_r5_wb_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wb |-> res_valid);

    // R10: an undefined code with idle unit yields no digit
    a_r10_undef_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.busy && !dec_ctl.valid) |-> !res_valid);

endmodule

// File: tb/digit_alu_test.sv
module digit_alu_test;
    import digit_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] op = '0;
    logic       wide = 1'b0;
    logic       swap = 1'b0;
    logic       c_in = 1'b0;
    logic [1:0] a_dig = '0;
    logic [1:0] b_dig = '0;
    logic [1:0] res_dig;
    logic       res_valid, wb, done;
    logic       flag_c, flag_z, flag_s, flag_v;

    int errors = 0;
    int checks = 0;
    logic ec = 0, ez = 0, es = 0, ev = 0;

    always #4 clk = ~clk;

    digit_alu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .swap(swap), .c_in(c_in), .a_dig(a_dig), .b_dig(b_dig),
        .res_dig(res_dig), .res_valid(res_valid), .wb(wb), .done(done),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void ref_op(input logic [4:0] o, input logic w, input logic sw,
                                   input logic ci_f, input logic [15:0] a, input logic [15:0] b,
                                   output logic [15:0] res, output logic c, output logic z,
                                   output logic s, output logic v, output logic wbe);
        int n;
        logic [16:0] mask, x, y, av, bv, sum;
        logic ci;
        logic arith;
        n = w ? 16 : 8;
        mask = (17'd1 << n) - 17'd1;
        x = {1'b0, (sw ? b : a)};
        y = {1'b0, (sw ? a : b)};
        arith = 1'b1; wbe = 1'b1; ci = 1'b0; av = '0; bv = '0; res = '0;
        case (o)
            5'd0:  begin av = x;  bv = y;  ci = 1'b0; end
            5'd1:  begin av = x;  bv = y;  ci = ci_f; end
            5'd2:  begin av = x;  bv = ~y; ci = 1'b1; end
            5'd3:  begin av = x;  bv = ~y; ci = ci_f; end
            5'd7:  begin av = x;  bv = ~y; ci = 1'b1; wbe = 1'b0; end
            5'd9:  begin av = '0; bv = ~y; ci = 1'b1; end
            5'd10: begin av = '0; bv = ~y; ci = ci_f; end
            5'd11: begin av = ~x; bv = y;  ci = 1'b1; end
            5'd12: begin av = ~x; bv = y;  ci = ci_f; end
            5'd4:  begin arith = 0; res = 16'(x & y); end
            5'd5:  begin arith = 0; res = 16'(x | y); end
            5'd6:  begin arith = 0; res = 16'(x ^ y); end
            5'd8:  begin arith = 0; res = 16'(x & y); wbe = 1'b0; end
            5'd13: begin arith = 0; res = 16'(x & ~y); end
            5'd14: begin arith = 0; res = 16'(x | ~y); end
            5'd15: begin arith = 0; res = 16'(x ^ ~y); end
            default: begin arith = 0; res = 16'(~y); end
        endcase
        if (arith) begin
            av &= mask; bv &= mask;
            sum = av + bv + {16'd0, ci};
            res = 16'(sum & mask);
            c = sum[n];
            v = (av[n-1] == bv[n-1]) && (sum[n-1] != av[n-1]);
        end else begin
            res = 16'({1'b0, res} & mask);
            c = 1'b0; v = 1'b0;
        end
        z = (res == 16'd0);
        s = res[n-1];
    endfunction

    // Runs one operation; glitch drives conflicting start/controls mid-operation (R9)
    task automatic run_op(input string req, input logic [4:0] o, input logic w, input logic sw,
                          input logic ci_f, input logic [15:0] a, input logic [15:0] b,
                          input logic glitch);
        logic [15:0] res;
        logic c, z, s, v, wbe;
        int nd;
        ref_op(o, w, sw, ci_f, a, b, res, c, z, s, v, wbe);
        nd = w ? 8 : 4;
        for (int i = 0; i < nd; i++) begin
            @(negedge clk);
            if (i == 0) begin
                start = 1'b1; op = o; wide = w; swap = sw; c_in = ci_f;
            end else if (glitch) begin
                start = 1'b1; op = 5'd16; wide = ~w; swap = ~sw; c_in = ~ci_f;
            end else begin
                start = 1'b0;
            end
            a_dig = 2'(a >> (2 * i));
            b_dig = 2'(b >> (2 * i));
            #1;
            // R1 digit value and timing, R2 done, R5 writeback
            check({req, " R1 digit"}, {6'd0, res_dig}, {6'd0, 2'(res >> (2 * i))});
            check({req, " R2 R5 ctl"}, {5'd0, res_valid, done, wb},
                  {5'd0, 1'b1, 1'(i == nd - 1), wbe});
        end
        @(negedge clk);
        start = 1'b0; op = '0; a_dig = '0; b_dig = '0;
        #1;
        ec = c; ez = z; es = s; ev = v;
        check({req, " R1 idle"}, {7'd0, res_valid}, 8'd0);
        check({req, " R8 flags"}, {4'd0, flag_c, flag_z, flag_s, flag_v}, {4'd0, ec, ez, es, ev});
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        check("R11 reset", {2'd0, res_valid, wb, flag_c, flag_z, flag_s, flag_v}, 8'd0);
        check("R11 done", {7'd0, done}, 8'd0);
        rst_n = 1'b1;

        run_op("R3 add ovf",     5'd0,  0, 0, 0, 16'h007F, 16'h0001, 0);
        run_op("R3 add wrap",    5'd0,  1, 0, 0, 16'hFFFF, 16'h0001, 0);
        run_op("R3 adc",         5'd1,  1, 0, 1, 16'h1234, 16'h0FFF, 0);
        run_op("R3 sub borrow",  5'd2,  0, 0, 0, 16'h0010, 16'h0020, 0);
        run_op("R3 sbc",         5'd3,  1, 0, 0, 16'h8000, 16'h0001, 0);
        run_op("R4 and",         5'd4,  0, 0, 0, 16'h00F0, 16'h003C, 0);
        run_op("R4 or",          5'd5,  1, 0, 0, 16'hA000, 16'h0505, 0);
        run_op("R4 xor zero",    5'd6,  1, 0, 0, 16'h5A5A, 16'h5A5A, 0);
        run_op("R5 cmp",         5'd7,  0, 0, 0, 16'h0042, 16'h0042, 0);
        run_op("R5 test",        5'd8,  1, 0, 0, 16'h8001, 16'h8000, 0);
        run_op("R6 neg min",     5'd9,  0, 0, 0, 16'h0000, 16'h0080, 0);
        run_op("R6 neg zero",    5'd9,  1, 0, 0, 16'h0000, 16'h0000, 0);
        run_op("R6 negc",        5'd10, 0, 0, 0, 16'h0000, 16'h0005, 0);
        run_op("R6 rsub",        5'd11, 1, 0, 0, 16'h0003, 16'h0001, 0);
        run_op("R6 rsbc",        5'd12, 0, 0, 1, 16'h0010, 16'h0090, 0);
        run_op("R4 andn",        5'd13, 0, 0, 0, 16'h00FF, 16'h000F, 0);
        run_op("R4 orn",         5'd14, 1, 0, 0, 16'h0000, 16'hFFFF, 0);
        run_op("R4 xorn",        5'd15, 1, 0, 0, 16'h1234, 16'h4321, 0);
        run_op("R4 not",         5'd16, 0, 0, 0, 16'h0000, 16'h00C3, 0);
        run_op("R7 swap sub",    5'd2,  1, 1, 0, 16'h0005, 16'h0100, 0);
        run_op("R7 swap andn",   5'd13, 0, 1, 0, 16'h000F, 16'h00FF, 0);
        run_op("R9 hold 8",      5'd0,  0, 0, 1, 16'h00C8, 16'h0039, 1);
        run_op("R9 hold 16",     5'd12, 1, 1, 0, 16'h7000, 16'h9000, 1);

        // R10: undefined code is ignored, flags unchanged
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start = (i == 0); op = 5'd21; wide = 1'b0; a_dig = 2'd3; b_dig = 2'd1;
            #1;
            check("R10 undef", {5'd0, res_valid, wb, done}, 8'd0);
        end
        @(negedge clk);
        start = 1'b0; op = '0;
        #1;
        check("R10 flags kept", {4'd0, flag_c, flag_z, flag_s, flag_v}, {4'd0, ec, ez, es, ev});

        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 120; k++) begin
            logic [15:0] ra, rb;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            ra = lfsr[31:16];
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            rb = lfsr[31:16];
            run_op("R3 R6 sweep", 5'(lfsr[4:0] % 17), lfsr[5], lfsr[6], lfsr[7], ra, rb, lfsr[8]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule